// File: doc/BRIEF.md
# Oversampled SPI Slave Frame Engine

This block is a full-duplex SPI slave in mode 0 (serial clock idles low, data is sampled on its rising edge and changed on its falling edge). It lives entirely in one fast system clock domain. The serial clock, chip-select and MOSI pins are plain data inputs. Each of them passes through a synchroniser, and a further register lets the block find the edges of the serial clock and chip-select by comparing successive samples. The serial clock should run at no more than a quarter of the system clock rate; the edges are only seen reliably with that much margin.

Each assertion of chip-select moves one fixed-length frame each way. When chip-select falls, the block copies a parallel transmit word into its output shift register, so the host's first bit is already valid. That word holds status such as Hall sensor bits and summed current readings. When chip-select rises after exactly the right number of serial clock rising edges, the block publishes the received word and pulses a one-cycle done strobe. The received word carries PWM match values, and the strobe can restart downstream measurement. A frame that ends with any other bit count is dropped, and an error strobe is pulsed instead.

Top module: `spi_frame_slave`

## Requirements
- R1: After reset, `miso_out`, `frame_done`, `frame_err` and every bit of `rx_word` are 0.
- R2: The transmit word is taken from `tx_word` when the synchronised chip-select falls. Changes to `tx_word` later in the same frame do not reach `miso_out`.
- R3: Data goes out MSB first. Before the first serial clock rising edge, `miso_out` shows bit FRAME_BITS-1 of the loaded word. Each serial clock falling edge advances it by one bit, and zeros follow once the word is used up.
- R4: On each serial clock rising edge inside a frame, the synchronised MOSI level is shifted in. After a complete frame, `rx_word` holds the first received bit at bit FRAME_BITS-1 and the last at bit 0.
- R5: When chip-select rises after exactly FRAME_BITS serial clock rising edges, `frame_done` is high for exactly one cycle. `rx_word` takes the new value in that same cycle.
- R6: When chip-select rises after any other number of rising edges (fewer or more), `frame_err` is high for exactly one cycle. `frame_done` stays low and `rx_word` keeps its previous value.
- R7: While chip-select is high, `miso_out` is 0 and serial clock edges change nothing. No strobe fires, `rx_word` is unchanged, and the next frame is still received correctly.
- R8: Back-to-back frames separated by a chip-select high time of only a few system clocks each produce their own `frame_done`, and `rx_word` holds the later frame.
- R9: `frame_done` and `frame_err` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_in | input | 1 | Serial clock from the host, oversampled |
| csn_in | input | 1 | Active-low chip-select from the host |
| mosi_in | input | 1 | Serial data from the host |
| miso_out | output | 1 | Serial data to the host; 0 while deselected |
| tx_word | input | FRAME_BITS | Parallel word to transmit, loaded when chip-select falls |
| rx_word | output | FRAME_BITS | Last complete received word |
| frame_done | output | 1 | One-cycle strobe when a complete frame is committed |
| frame_err | output | 1 | One-cycle strobe when a frame ends with a wrong bit count |

## Verification
The bench builds the block with its default values: a 128-bit frame and two synchroniser stages. It drives a serial clock at one sixteenth of the system clock, so each serial clock half-period spans eight samples. That lets it use the full production frame length, including the frames of 127 and 129 bits that fall either side of the commit rule. The short gap between back-to-back frames only works because of the two-stage synchroniser and the edge register: a chip-select high pulse of three system clocks still produces a rising-edge detection.

// File: rtl/spi_frame_pkg.sv
package spi_frame_pkg;

  // Edge information for one oversampled input.
  typedef struct packed {
    logic level;
    logic rise;
    logic fall;
  } edge_info_t;

  // Counter width that holds FRAME_BITS+1 (the over-length bin).
  function automatic int cnt_width(input int frame_bits);
    return $clog2(frame_bits + 2);
  endfunction

endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync
  import spi_frame_pkg::*;
#(
  parameter int         STAGES  = 2,
  parameter int         WIDTH   = 3,
  parameter logic [WIDTH-1:0] IDLE_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_in,
  output edge_info_t       edge_out [WIDTH]
);

  localparam int DEPTH = STAGES + 1;  // sync stages plus one history register

  for (genvar g = 0; g < WIDTH; g++) begin : g_lane
    logic [DEPTH-1:0] pipe_q;
    logic [DEPTH-1:0] pipe_d;

    always_comb begin
      pipe_d = {pipe_q[DEPTH-2:0], pin_in[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pipe_q <= {DEPTH{IDLE_VAL[g]}};
      end else begin
        pipe_q <= pipe_d;
      end
    end

    always_comb begin
      edge_out[g].level = pipe_q[STAGES-1];
      edge_out[g].rise  = pipe_q[STAGES-1] & ~pipe_q[STAGES];
      edge_out[g].fall  = ~pipe_q[STAGES-1] & pipe_q[STAGES];
    end
  end

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
  import spi_frame_pkg::*;
#(
  parameter int FRAME_BITS = 128,
  localparam int CW        = cnt_width(FRAME_BITS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sel_active,
  input  logic                  sel_fall,
  input  logic                  sck_rise,
  input  logic                  sck_fall,
  input  logic                  data_bit,
  input  logic [FRAME_BITS-1:0] load_word,
  output logic                  tx_head,
  output logic [FRAME_BITS-1:0] shift_in_word,
  output logic [CW-1:0]         edge_count
);

  localparam logic [CW-1:0] CNT_SAT = CW'(FRAME_BITS + 1);

  logic [FRAME_BITS-1:0] tx_q, tx_d;
  logic [FRAME_BITS-1:0] rx_q, rx_d;
  logic [CW-1:0]         cnt_q, cnt_d;
  logic                  tx_en, rx_en, cnt_en;

  // Next-state logic. A chip-select fall wins over any serial clock edge.
  always_comb begin
    tx_d   = tx_q;
    rx_d   = rx_q;
    cnt_d  = cnt_q;
    tx_en  = 1'b0;
    rx_en  = 1'b0;
    cnt_en = 1'b0;
    if (sel_fall) begin
      tx_d   = load_word;
      tx_en  = 1'b1;
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (sel_active) begin
      if (sck_rise) begin
        rx_d   = {rx_q[FRAME_BITS-2:0], data_bit};
        rx_en  = 1'b1;
        cnt_en = (cnt_q != CNT_SAT);
        cnt_d  = cnt_q + CW'(1);
      end
      if (sck_fall) begin
        tx_d  = {tx_q[FRAME_BITS-2:0], 1'b0};
        tx_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      rx_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (tx_en)  tx_q  <= tx_d;
      if (rx_en)  rx_q  <= rx_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign tx_head       = tx_q[FRAME_BITS-1];
  assign shift_in_word = rx_q;
  assign edge_count    = cnt_q;

endmodule

// File: rtl/spi_frame_commit.sv
module spi_frame_commit
  import spi_frame_pkg::*;
#(
  parameter int FRAME_BITS = 128,
  localparam int CW        = cnt_width(FRAME_BITS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sel_rise,
  input  logic [CW-1:0]         edge_count,
  input  logic [FRAME_BITS-1:0] shift_in_word,
  output logic [FRAME_BITS-1:0] held_word,
  output logic                  done_pulse,
  output logic                  bad_pulse
);

  localparam logic [CW-1:0] CNT_FULL = CW'(FRAME_BITS);

  logic                  count_ok;
  logic                  word_en;
  logic                  done_d, bad_d;
  logic                  done_q, bad_q;
  logic [FRAME_BITS-1:0] word_q;

  always_comb begin
    count_ok = (edge_count == CNT_FULL);
    word_en  = sel_rise & count_ok;
    done_d   = sel_rise & count_ok;
    bad_d    = sel_rise & ~count_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      done_q <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      if (word_en) word_q <= shift_in_word;
      done_q <= done_d;
      bad_q  <= bad_d;
    end
  end

  assign held_word  = word_q;
  assign done_pulse = done_q;
  assign bad_pulse  = bad_q;

endmodule

// File: rtl/spi_frame_slave.sv
module spi_frame_slave
  import spi_frame_pkg::*;
#(
  parameter int FRAME_BITS  = 128,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sclk_in,
  input  logic                  csn_in,
  input  logic                  mosi_in,
  output logic                  miso_out,
  input  logic [FRAME_BITS-1:0] tx_word,
  output logic [FRAME_BITS-1:0] rx_word,
  output logic                  frame_done,
  output logic                  frame_err
);

  localparam int CW    = cnt_width(FRAME_BITS);
  localparam int L_SCK = 0;
  localparam int L_SEL = 1;
  localparam int L_DAT = 2;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe_q[1];

  edge_info_t edges [3];
  logic       sel_active;
  logic       tx_head;
  logic [FRAME_BITS-1:0] rx_shift;
  logic [CW-1:0]         bit_cnt;

  // Chip-select idles high; serial clock and data idle low.
  spi_edge_sync #(
    .STAGES   (SYNC_STAGES),
    .WIDTH    (3),
    .IDLE_VAL (3'b010)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .pin_in   ({mosi_in, csn_in, sclk_in}),
    .edge_out (edges)
  );

  assign sel_active = ~edges[L_SEL].level;

  spi_shift_core #(
    .FRAME_BITS (FRAME_BITS)
  ) u_core (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .sel_active    (sel_active),
    .sel_fall      (edges[L_SEL].fall),
    .sck_rise      (edges[L_SCK].rise),
    .sck_fall      (edges[L_SCK].fall),
    .data_bit      (edges[L_DAT].level),
    .load_word     (tx_word),
    .tx_head       (tx_head),
    .shift_in_word (rx_shift),
    .edge_count    (bit_cnt)
  );

  spi_frame_commit #(
    .FRAME_BITS (FRAME_BITS)
  ) u_commit (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .sel_rise      (edges[L_SEL].rise),
    .edge_count    (bit_cnt),
    .shift_in_word (rx_shift),
    .held_word     (rx_word),
    .done_pulse    (frame_done),
    .bad_pulse     (frame_err)
  );

  assign miso_out = sel_active & tx_head;

endmodule

// File: rtl/spi_frame_slave_chk.sv
module spi_frame_slave_chk #(
  parameter int FRAME_BITS = 128
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  csn_in,
  input logic                  miso_out,
  input logic [FRAME_BITS-1:0] rx_word,
  input logic                  frame_done,
  input logic                  frame_err
);

  // Counts cycles since reset so that $past never reaches before it.
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= 2'd0;
    end else if (age_q != 2'd3) begin
      age_q <= age_q + 2'd1;
    end
  end

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  assert_err_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);

  assert_strobes_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_done && frame_err));

  assert_word_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q != 2'd0 && !frame_done) |-> $stable(rx_word));

  assert_miso_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3 && $past(csn_in) && $past(csn_in, 2) && $past(csn_in, 3))
      |-> !miso_out);

endmodule

bind spi_frame_slave spi_frame_slave_chk #(
  .FRAME_BITS (FRAME_BITS)
) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .csn_in     (csn_in),
  .miso_out   (miso_out),
  .rx_word    (rx_word),
  .frame_done (frame_done),
  .frame_err  (frame_err)
);

// File: tb/test_spi_frame_slave.sv
module test_spi_frame_slave;

  localparam int N    = 128;
  localparam int HALF = 8;  // system clocks per serial clock half-period

  typedef struct packed {
    logic [7:0]   nbits;
    logic [N-1:0] tx;
    logic [N-1:0] mo;
  } vec_t;

  localparam int NVEC = 4;
  localparam vec_t VECS [NVEC] = '{
    '{8'd128, {4{32'hC3A5_0F1E}}, {8{16'h1234}}},
    '{8'd128, {64'hFFFF_FFFF_0000_0001, 64'h8000_0000_5555_AAAA}, {N{1'b1}}},
    '{8'd127, {N{1'b1}}, {16{8'h6D}}},
    '{8'd128, {2{64'h0123_4567_89AB_CDEF}}, {4{32'h8001_7FFE}}}
  };

  logic         clk;
  logic         rst_n;
  logic         sclk_in, csn_in, mosi_in;
  logic         miso_out;
  logic [N-1:0] tx_word;
  logic [N-1:0] rx_word;
  logic         frame_done, frame_err;

  int checks;
  int fails;
  int done_seen;
  int err_seen;
  int wide_pulse;
  int cyc;

  spi_frame_slave #(.FRAME_BITS(N), .SYNC_STAGES(2)) i_spi_frame_slave (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk_in    (sclk_in),
    .csn_in     (csn_in),
    .mosi_in    (mosi_in),
    .miso_out   (miso_out),
    .tx_word    (tx_word),
    .rx_word    (rx_word),
    .frame_done (frame_done),
    .frame_err  (frame_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  logic prev_done, prev_err;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (frame_done) done_seen <= done_seen + 1;
    if (frame_err)  err_seen  <= err_seen + 1;
    if ((frame_done && prev_done) || (frame_err && prev_err) || (frame_done && frame_err))
      wide_pulse <= wide_pulse + 1;
    prev_done <= frame_done;
    prev_err  <= frame_err;
  end

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below 150000", cyc);
      finish_run();
    end
  end

  task automatic check(input bit ok, input string req, input logic [N-1:0] act,
                       input logic [N-1:0] exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // One frame of nbits serial clocks. Optionally changes tx_word mid-frame.
  task automatic xfer(input int nbits, input logic [N-1:0] tx, input logic [N-1:0] mo,
                      input bit swap_tx, input int gap, output logic [N-1:0] cap);
    cap = '0;
    tx_word = tx;
    @(negedge clk);
    csn_in = 1'b0;
    wait_clk(HALF);
    if (swap_tx) tx_word = ~tx;
    for (int i = 0; i < nbits; i++) begin
      mosi_in = (i < N) ? mo[N-1-i] : 1'b0;
      wait_clk(HALF);
      if (i < N) cap[N-1-i] = miso_out;
      sclk_in = 1'b1;
      wait_clk(HALF);
      sclk_in = 1'b0;
    end
    wait_clk(HALF);
    csn_in = 1'b1;
    wait_clk(gap);
  endtask

  logic [N-1:0] cap;
  logic [N-1:0] exp_cap;
  logic [N-1:0] last_rx;
  int d0, e0;
  bit miso_quiet;

  initial begin
    checks = 0; fails = 0; done_seen = 0; err_seen = 0; wide_pulse = 0; cyc = 0;
    prev_done = 1'b0; prev_err = 1'b0;
    rst_n = 1'b0; sclk_in = 1'b0; csn_in = 1'b1; mosi_in = 1'b0; tx_word = '0;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(6);

    // R1 reset state
    check(miso_out == 1'b0, "R1 miso", N'(miso_out), '0);
    check(frame_done == 1'b0, "R1 frame_done", N'(frame_done), '0);
    check(frame_err == 1'b0, "R1 frame_err", N'(frame_err), '0);
    check(rx_word == '0, "R1 rx_word", rx_word, '0);

    // Table walk: R3, R4, R5, R6
    last_rx = '0;
    for (int v = 0; v < NVEC; v++) begin
      d0 = done_seen; e0 = err_seen;
      xfer(int'(VECS[v].nbits), VECS[v].tx, VECS[v].mo, 1'b0, 10, cap);
      exp_cap = VECS[v].tx;
      if (VECS[v].nbits < N) begin
        exp_cap = exp_cap & ~({N{1'b1}} >> VECS[v].nbits);
        cap     = cap & ~({N{1'b1}} >> VECS[v].nbits);
      end
      check(cap == exp_cap, "R3 miso bits MSB first", cap, exp_cap);
      if (VECS[v].nbits == 8'(N)) begin
        check(done_seen == d0 + 1, "R5 done count", N'(done_seen - d0), N'(1));
        check(err_seen == e0, "R6 no err on full frame", N'(err_seen - e0), '0);
        check(rx_word == VECS[v].mo, "R4 rx_word", rx_word, VECS[v].mo);
        last_rx = VECS[v].mo;
      end else begin
        check(err_seen == e0 + 1, "R6 err on short frame", N'(err_seen - e0), N'(1));
        check(done_seen == d0, "R6 no done on short frame", N'(done_seen - d0), '0);
        check(rx_word == last_rx, "R6 rx_word kept", rx_word, last_rx);
      end
    end

    // R6 over-length frame
    d0 = done_seen; e0 = err_seen;
    xfer(N + 1, {N{1'b0}}, {N{1'b1}} >> 3, 1'b0, 10, cap);
    check(err_seen == e0 + 1, "R6 err on long frame", N'(err_seen - e0), N'(1));
    check(done_seen == d0, "R6 no done on long frame", N'(done_seen - d0), '0);
    check(rx_word == last_rx, "R6 rx_word kept after long", rx_word, last_rx);

    // R7 serial clock toggling while deselected
    d0 = done_seen; e0 = err_seen;
    miso_quiet = 1'b1;
    tx_word = {N{1'b1}};
    mosi_in = 1'b1;
    for (int i = 0; i < 20; i++) begin
      wait_clk(HALF);
      if (miso_out) miso_quiet = 1'b0;
      sclk_in = 1'b1;
      wait_clk(HALF);
      if (miso_out) miso_quiet = 1'b0;
      sclk_in = 1'b0;
    end
    wait_clk(10);
    check(miso_quiet, "R7 miso low while deselected", N'(!miso_quiet), '0);
    check(done_seen == d0 && err_seen == e0, "R7 no strobes",
          N'(done_seen - d0 + err_seen - e0), '0);
    check(rx_word == last_rx, "R7 rx_word unchanged", rx_word, last_rx);
    xfer(N, {N{1'b0}}, {4{32'h0F0F_A0A0}}, 1'b0, 10, cap);
    check(rx_word == {4{32'h0F0F_A0A0}}, "R7 next frame intact", rx_word, {4{32'h0F0F_A0A0}});

    // R2 tx_word change mid-frame is ignored
    xfer(N, {2{64'hA5A5_0000_FFFF_1234}}, '0, 1'b1, 10, cap);
    check(cap == {2{64'hA5A5_0000_FFFF_1234}}, "R2 load at select fall", cap,
          {2{64'hA5A5_0000_FFFF_1234}});

    // R8 back-to-back frames with a short deselect gap
    d0 = done_seen;
    xfer(N, '0, {N{1'b1}}, 1'b0, 3, cap);
    xfer(N, '0, {16{8'h3C}}, 1'b0, 10, cap);
    check(done_seen == d0 + 2, "R8 two done strobes", N'(done_seen - d0), N'(2));
    check(rx_word == {16{8'h3C}}, "R8 rx_word holds later frame", rx_word, {16{8'h3C}});

    // R5, R6, R9 strobe width and exclusivity over the whole run
    check(wide_pulse == 0, "R9 strobes single and exclusive", N'(wide_pulse), '0);

    finish_run();
  end

endmodule